// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with a single down counter that runs through two timeout windows in turn. Software loads two preload values and sets an enable bit. The counter then takes the first preload and counts down on a slow tick. The tick comes from a clock prescaler, so one count is about a microsecond with the default divider. Software must write the refresh register often enough to restart the first window. If it does not, the counter reaches zero and the block raises an interrupt on one of two lines. Software chooses between a system-management interrupt line and a regular IRQ line. The counter then reloads from the second preload and starts the second window.

If the second window also runs out, the block drives its active-low timeout output low. The output stays low until the block itself is reset. Disabling the timer, refreshing it or clearing the interrupt flag does not release it. A small register interface provides a write port and a combinational read port. It holds the control bits and the two preloads, and it reports status and the current count. Bus bridging and interrupt routing happen outside the block.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, `tout_n_o` is 1 and `smi_o` and `irq_o` are 0. The status register (address 6) reads 0, and the preload registers read 0.
- R2: Address 0 is the control register: bit 0 is enable and bit 1 selects the interrupt line. One cycle after enable is written to 1 from idle, the counter holds preload one and the status stage field (bits 1:0) reads 1. The counter is read at address 7, low word.
- R3: The first-stage expiry comes (P1+1)·DIV cycles after preload one is loaded. The block then sets the pending flag (status bit 2) and raises `smi_o` when control bit 1 is 0, or `irq_o` when it is 1.
- R4: At the first-stage expiry, the counter loads preload two and the stage field reads 2. (P2+1)·DIV cycles later, `tout_n_o` goes low, the timeout flag (status bit 3) sets and the stage field reads 3.
- R5: Once `tout_n_o` is low, it stays low through refresh writes, status clears and disable writes. Only reset releases it.
- R6: A write to address 1 while enabled in stage 1 or 2 reloads preload one, returns the stage field to 1, clears the pending flag and restarts the tick phase. The next expiry then follows (P1+1)·DIV cycles after that write.
- R7: Writing enable to 0 returns the stage field to 0, and the counter value then stays frozen.
- R8: Writing the status register with bit 2 set clears the pending flag and drops the interrupt line, without changing the stage.
- R9: Preloads are 35 bits wide. Each has a low word and a high word: preload one at addresses 2 and 3, preload two at 4 and 5. A high-word write keeps only bits 2:0, and both words read back.
- R10: A preload of 0 expires on the first tick, DIV cycles after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | DATA_W | Combinational read data |
| smi_o | output | 1 | First-stage system-management interrupt |
| irq_o | output | 1 | First-stage regular interrupt |
| tout_n_o | output | 1 | Active-low final timeout, latched until reset |

## Verification
The assertions assume that each write strobe lasts one clock cycle and carries one address. They also assume that the refresh and status-clear strobes come only through that write port. The stimulus drives every write for exactly one cycle and only between clock edges. It waits on the cycle count so that refreshes land inside the first window. It disables the timer before the second window ends wherever a test must not reach the final timeout.

// File: rtl/twostage_wdt_pkg.sv
`timescale 1ns/1ps
// Package: shared stage encoding and register addresses of the two-stage watchdog.
// Assumes a 3-bit register address space.
package twostage_wdt_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FIRST   = 2'd1,
        ST_SECOND  = 2'd2,
        ST_EXPIRED = 2'd3
    } wdt_stage_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_KICK   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd2;  // preload n low word at 2 + 2n
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd7;
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
// Module: tick prescaler. Emits a one-cycle tick every DIV cycles while run is high.
// Assumes restart is asserted on every counter load so the tick phase starts afresh.
module wdt_prescaler #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;

    // Tick whenever the phase counter sits at its last value.
    assign tick = run && (div_q == LAST);

    // Advance the phase counter, clearing it on restart, stop or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV > 1) && tick |=> !tick);
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
// Module: register file of the watchdog. Holds control bits and two split preloads,
// decodes the refresh and pending-clear strobes, and muxes status readback.
// Assumes CNT_W > DATA_W and CNT_W - DATA_W <= DATA_W.
module wdt_regs
    import twostage_wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  wdt_stage_e        stage_i,
    input  logic              pending_i,
    input  logic              timed_out_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              en_o,
    output logic              sel_irq_o,
    output logic [CNT_W-1:0]  pre1_o,
    output logic [CNT_W-1:0]  pre2_o,
    output logic              kick_o,
    output logic              pend_clr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [CNT_W-1:0] pre_q [2];

    // Control bits: enable and interrupt line select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            sel_irq_o <= 1'b0;
        end else if (wr_en_i && wr_addr_i == A_CTRL) begin
            en_o      <= wr_data_i[0];
            sel_irq_o <= wr_data_i[1];
        end
    end

    // One preload register per stage, low and high words at adjacent addresses.
    for (genvar g = 0; g < 2; g++) begin : g_pre
        localparam logic [ADDR_W-1:0] LO = A_PRE_LO + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] HI = LO + ADDR_W'(1);
        // Capture preload words written by software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[g] <= '0;
            end else if (wr_en_i && wr_addr_i == LO) begin
                pre_q[g][DATA_W-1:0] <= wr_data_i;
            end else if (wr_en_i && wr_addr_i == HI) begin
                pre_q[g][CNT_W-1:DATA_W] <= wr_data_i[HI_W-1:0];
            end
        end
    end

    assign pre1_o     = pre_q[0];
    assign pre2_o     = pre_q[1];
    assign kick_o     = wr_en_i && wr_addr_i == A_KICK;
    assign pend_clr_o = wr_en_i && wr_addr_i == A_STATUS && wr_data_i[2];

    // Readback multiplexer.
    always_comb begin
        case (rd_addr_i)
            A_CTRL:   rd_data_o = DATA_W'({sel_irq_o, en_o});
            3'd2:     rd_data_o = pre_q[0][DATA_W-1:0];
            3'd3:     rd_data_o = DATA_W'(pre_q[0][CNT_W-1:DATA_W]);
            3'd4:     rd_data_o = pre_q[1][DATA_W-1:0];
            3'd5:     rd_data_o = DATA_W'(pre_q[1][CNT_W-1:DATA_W]);
            A_STATUS: rd_data_o = DATA_W'({timed_out_i, pending_i, stage_i});
            A_COUNT:  rd_data_o = cnt_i[DATA_W-1:0];
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
// Module: two-stage countdown engine. One down counter serves both stages; expiry of
// the first stage sets the pending flag and reloads preload two, expiry of the second
// latches the timeout. Assumes kick and pend_clr are single-cycle strobes.
module wdt_core
    import twostage_wdt_pkg::*;
#(
    parameter int CNT_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             kick_i,
    input  logic             pend_clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] pre1_i,
    input  logic [CNT_W-1:0] pre2_i,
    output wdt_stage_e       stage_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pending_o,
    output logic             timed_out_o,
    output logic             load_o
);
    wdt_stage_e       stage_q, stage_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, tout_q;
    logic             exp1, exp2, kick_ok;

    // Next-state selection: latched timeout, disable, (re)start, then tick countdown.
    always_comb begin
        stage_d = stage_q;
        cnt_d   = cnt_q;
        load_o  = 1'b0;
        exp1    = 1'b0;
        exp2    = 1'b0;
        kick_ok = 1'b0;
        if (stage_q == ST_EXPIRED) begin
            stage_d = ST_EXPIRED;
        end else if (!en_i) begin
            stage_d = ST_IDLE;
        end else if (kick_i || stage_q == ST_IDLE) begin
            kick_ok = kick_i;
            cnt_d   = pre1_i;
            stage_d = ST_FIRST;
            load_o  = 1'b1;
        end else if (tick_i) begin
            if (cnt_q != '0) begin
                cnt_d = cnt_q - CNT_W'(1);
            end else if (stage_q == ST_FIRST) begin
                exp1    = 1'b1;
                cnt_d   = pre2_i;
                stage_d = ST_SECOND;
                load_o  = 1'b1;
            end else begin
                exp2    = 1'b1;
                stage_d = ST_EXPIRED;
            end
        end
    end

    // Stage and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            stage_q <= stage_d;
            cnt_q   <= cnt_d;
        end
    end

    // Pending flag: set on first expiry, cleared by refresh or write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (exp1) begin
            pend_q <= 1'b1;
        end else if (kick_ok || pend_clr_i) begin
            pend_q <= 1'b0;
        end
    end

    // Timeout latch, released only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q <= 1'b0;
        end else if (exp2) begin
            tout_q <= 1'b1;
        end
    end

    assign stage_o     = stage_q;
    assign cnt_o       = cnt_q;
    assign pending_o   = pend_q;
    assign timed_out_o = tout_q;

    assert_first_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !kick_i && tick_i && stage_q == ST_FIRST && cnt_q == '0
        |=> pend_q && stage_q == ST_SECOND && cnt_q == $past(pre2_i));
    assert_second_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !kick_i && tick_i && stage_q == ST_SECOND && cnt_q == '0
        |=> tout_q && stage_q == ST_EXPIRED);
    assert_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i && en_i && (stage_q == ST_FIRST || stage_q == ST_SECOND)
        |=> stage_q == ST_FIRST && !pend_q && cnt_q == $past(pre1_i));
    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (stage_q == ST_IDLE || stage_q == ST_EXPIRED));
    assert_disable_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_q));
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_i && !(tick_i && stage_q == ST_FIRST && cnt_q == '0) |=> !pend_q);
endmodule

// File: rtl/twostage_wdt.sv
`timescale 1ns/1ps
// Module: top of the two-stage watchdog. Connects registers, prescaler and countdown
// engine, and drives the two interrupt lines and the active-low timeout output.
// Assumes DIV is the clock-to-tick ratio (50 gives a 1 us tick at 50 MHz).
module twostage_wdt
    import twostage_wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 35,
    parameter int DIV    = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              smi_o,
    output logic              irq_o,
    output logic              tout_n_o
);
    logic             en, sel_irq, kick, pend_clr, tick, load, pending, timed_out, run;
    logic [CNT_W-1:0] pre1, pre2, cnt;
    wdt_stage_e       stage;

    wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .stage_i(stage),
        .pending_i(pending), .timed_out_i(timed_out), .cnt_i(cnt), .en_o(en),
        .sel_irq_o(sel_irq), .pre1_o(pre1), .pre2_o(pre2), .kick_o(kick),
        .pend_clr_o(pend_clr), .rd_data_o(rd_data_o)
    );

    assign run = (stage == ST_FIRST) || (stage == ST_SECOND);

    wdt_prescaler #(.DIV(DIV)) i_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load), .tick(tick)
    );

    wdt_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .en_i(en), .kick_i(kick), .pend_clr_i(pend_clr),
        .tick_i(tick), .pre1_i(pre1), .pre2_i(pre2), .stage_o(stage), .cnt_o(cnt),
        .pending_o(pending), .timed_out_o(timed_out), .load_o(load)
    );

    assign smi_o    = pending && !sel_irq;
    assign irq_o    = pending && sel_irq;
    assign tout_n_o = !timed_out;

    assert_tout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tout_n_o |=> !tout_n_o);
endmodule

// File: tb/test_twostage_wdt.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected output events (interrupt rise, timeout fall) with
// their cycle numbers, plus direct register readback checks.
module test_twostage_wdt;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        smi_o, irq_o, tout_n_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;  // 0 irq rise, 1 smi rise, 2 tout fall
        int    at;
        string req;
    } ev_t;
    ev_t sbq[$];

    twostage_wdt #(.DIV(DIV)) i_twostage_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .smi_o(smi_o), .irq_o(irq_o), .tout_n_o(tout_n_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: one-cycle write; returns the edge number that captured it.
    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        e = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic expect_ev(input int kind, input int at, input string req);
        ev_t x;
        x.kind = kind; x.at = at; x.req = req;
        sbq.push_back(x);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: pop and compare on each observed output event.
    task automatic got(input int kind);
        ev_t x;
        checks++;
        if (sbq.size() == 0) begin
            errors++;
            $display("FAIL R3/R4 unexpected event: actual=kind%0d@%0d expected=none", kind, cyc);
        end else begin
            x = sbq.pop_front();
            if (x.kind != kind || x.at != cyc) begin
                errors++;
                $display("FAIL %s: actual=kind%0d@%0d expected=kind%0d@%0d",
                         x.req, kind, cyc, x.kind, x.at);
            end
        end
    endtask

    logic irq_p = 1'b0, smi_p = 1'b0, tout_p = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (irq_o && !irq_p) got(0);
            if (smi_o && !smi_p) got(1);
            if (!tout_n_o && tout_p) got(2);
        end
        irq_p = irq_o; smi_p = smi_o; tout_p = tout_n_o;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=cycle %0d expected=finished", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int e, r, r2, w, d;
        logic [31:0] v, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tout_n_o", 32'(tout_n_o), 1);
        chk("R1 smi_o", 32'(smi_o), 0);
        chk("R1 irq_o", 32'(irq_o), 0);
        rd(3'd6, v); chk("R1 status", v, 0);
        rd(3'd2, v); chk("R1 preload", v, 0);

        // R9 split preload readback
        wr(3'd3, 32'hFFFF_FFFF, e); rd(3'd3, v); chk("R9 hi truncated", v, 7);
        wr(3'd2, 32'h1234_5678, e); rd(3'd2, v); chk("R9 lo", v, 32'h1234_5678);
        wr(3'd5, 32'h0000_000A, e); rd(3'd5, v); chk("R9 pre2 hi", v, 2);

        // Full two-stage run with IRQ line: P1=3, P2=2
        wr(3'd3, 0, e); wr(3'd2, 3, e); wr(3'd5, 0, e); wr(3'd4, 2, e);
        wr(3'd0, 32'h3, e);
        expect_ev(0, e + 1 + 4 * DIV, "R3 first expiry irq");
        expect_ev(2, e + 1 + 4 * DIV + 3 * DIV, "R4 second expiry");
        @(negedge clk);
        rd(3'd6, v); chk("R2 stage first", v, 1);
        rd(3'd7, v); chk("R2 count loaded", v, 3);
        wait_until(e + 2 + 4 * DIV);
        rd(3'd6, v); chk("R4 stage second pending", v, 6);
        rd(3'd7, v); chk("R4 count preload two", v, 2);
        wait_until(e + 2 + 7 * DIV);
        rd(3'd6, v); chk("R4 status expired", v, 15);
        chk("R4 tout_n_o low", 32'(tout_n_o), 0);
        // R5 latched through refresh, clear and disable
        wr(3'd1, 0, r); wr(3'd6, 4, w); wr(3'd0, 0, d);
        repeat (3) @(negedge clk);
        chk("R5 tout_n_o held", 32'(tout_n_o), 0);
        rd(3'd6, v); chk("R5 status", v, 11);
        do_reset();
        chk("R5 reset releases", 32'(tout_n_o), 1);

        // Refresh keeps it alive, SMI line selected
        wr(3'd2, 3, e); wr(3'd4, 2, e);
        wr(3'd0, 32'h1, e);
        r = e;
        for (int i = 0; i < 5; i++) begin
            repeat (6) @(negedge clk);
            wr(3'd1, 0, r);
        end
        expect_ev(1, r + 4 * DIV, "R6 expiry after last refresh");
        wait_until(r + 4 * DIV + 1);
        rd(3'd6, v); chk("R3 smi pending", v, 6);
        chk("R3 smi_o high", 32'(smi_o), 1);
        wr(3'd1, 0, r2);
        rd(3'd6, v); chk("R6 refresh in second stage", v, 1);
        chk("R6 smi_o cleared", 32'(smi_o), 0);
        expect_ev(1, r2 + 4 * DIV, "R6 expiry after second-stage refresh");
        wait_until(r2 + 4 * DIV + 1);
        wr(3'd6, 4, w);
        rd(3'd6, v); chk("R8 pending cleared stage kept", v, 2);
        chk("R8 smi_o low", 32'(smi_o), 0);
        wr(3'd0, 0, d);
        @(negedge clk);
        rd(3'd6, v); chk("R7 idle after disable", v, 0);
        rd(3'd7, c1);
        repeat (40) @(negedge clk);
        rd(3'd7, v); chk("R7 count frozen", v, c1);
        chk("R7 no timeout", 32'(tout_n_o), 1);

        // R10 zero preload expires on first tick
        wr(3'd2, 0, e); wr(3'd4, 1, e);
        wr(3'd0, 32'h3, e);
        expect_ev(0, e + 1 + DIV, "R10 zero preload expiry");
        expect_ev(2, e + 1 + DIV + 2 * DIV, "R4 second expiry after zero preload");
        wait_until(e + 3 + 3 * DIV);
        chk("R10 tout_n_o low", 32'(tout_n_o), 0);

        chk("R3 all expected events seen", 32'(sbq.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule